// File: doc/BRIEF.md
# Serial Port Expander with Parallel Capture and Latched Outputs

This block gives a narrow serial link sixteen extra inputs and sixteen extra outputs. One serial clock drives two shift paths. The capture path samples the sixteen input pins into a register when the load line is high. It then presents that word one bit at a time on the serial output, most significant bit first. The output path collects the serial input stream into a second shift register. It copies that register to the sixteen output latches only when a separate latch-enable line rises. The parallel outputs therefore stay steady while the next word is clocked in.

The serial clock, load, data and latch-enable lines are treated as asynchronous. They pass through a synchroniser into the system clock domain as one bundle, so load and data line up with the clock edge they belong to. Rising edges of the serial clock and of latch enable are then detected there. An active-low reset clears every register, including the output latches.

Top module: `spi_io_expander`

## Requirements
- R1: While rst_n is low, and right after it rises, sdo is 0 and pout is 0. The input shift register is cleared too: a latch-enable pulse before any serial clock edge leaves pout at 0.
- R2: On a rising sclk edge with ld high, the 16 pin_in values are captured into the capture register, and sdo then shows pin_in[15].
- R3: On each rising sclk edge with ld low, the capture register shifts toward its MSB with zero fill. After k such edges sdo equals the captured bit 15-k, and once all 16 bits have left, sdo is 0.
- R4: When ld is high on an sclk edge, the capture register is reloaded and is not shifted. A reload in the middle of a word puts the new pin_in[15] on sdo.
- R5: sdi is sampled on every rising sclk edge, whatever ld is, into the LSB of the input shift register. The first bit sent ends up at bit 15 after 16 edges.
- R6: pout holds its value while new data is shifted in, until latch enable rises.
- R7: A rising edge of le copies the input shift register to pout exactly once per pulse. Serial clock edges while le stays high do not change pout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| sclk | input | 1 | Serial clock (asynchronous) |
| ld | input | 1 | Load request for parallel capture |
| sdi | input | 1 | Serial data in, MSB first |
| le | input | 1 | Latch enable, rising edge transfers word |
| pin_in | input | 16 | Parallel input pins |
| sdo | output | 1 | Serial data out, MSB first |
| pout | output | 16 | Latched parallel outputs |

## Verification
The bench sweeps walking-one, walking-zero and mixed words through both paths at once, and compares every serial bit and every latched word with values it computes itself. A reversed bit order or a missing zero fill shows up as a wrong sdo bit at a known position. A design that lets load and shift happen on the same edge loses the reloaded MSB. Outputs that follow the shift register, instead of waiting for latch enable, change pout before the pulse. A level-triggered latch keeps copying while le is held high and picks up the bits shifted in after the edge. Reset is applied both from idle and mid-frame, and a latch pulse right after reset shows whether the hidden input register was cleared.

// File: rtl/spi_io_expander_pkg.sv
package spi_io_expander_pkg;
  localparam int unsigned PORT_W = 16;

  function automatic logic [PORT_W-1:0] push_lsb(input logic [PORT_W-1:0] sr, input logic b);
    return {sr[PORT_W-2:0], b};
  endfunction

  function automatic logic [PORT_W-1:0] drop_msb(input logic [PORT_W-1:0] sr);
    return {sr[PORT_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;

  // R7: an edge pulse lasts a single cycle
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/capture_shifter.sv
module capture_shifter
  import spi_io_expander_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [PORT_W-1:0] par,
  output logic              sout
);
  logic [PORT_W-1:0] cap_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cap_sr <= '0;
    else if (step && load)  cap_sr <= par;
    else if (step)          cap_sr <= drop_msb(cap_sr);
  end

  assign sout = cap_sr[PORT_W-1];

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load) |=> (sout == $past(par[PORT_W-1])));
  assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && load) |=> (cap_sr == $past(par)));
  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (sout == $past(cap_sr[PORT_W-2])));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cap_sr));
endmodule

// File: rtl/latch_shifter.sv
module latch_shifter
  import spi_io_expander_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              sin,
  input  logic              xfer,
  output logic [PORT_W-1:0] pout
);
  logic [PORT_W-1:0] in_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    in_sr <= '0;
    else if (step) in_sr <= push_lsb(in_sr, sin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pout <= '0;
    else if (xfer) pout <= in_sr;
  end

  assert_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (in_sr[0] == $past(sin)));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(pout));
  assert_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (pout == $past(in_sr)));
endmodule

// File: rtl/spi_io_expander.sv
module spi_io_expander
  import spi_io_expander_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              ld,
  input  logic              sdi,
  input  logic              le,
  input  logic [PORT_W-1:0] pin_in,
  output logic              sdo,
  output logic [PORT_W-1:0] pout
);
  localparam int unsigned BUS_W = 4;

  logic [BUS_W-1:0] raw_bus, sync_bus;
  logic sclk_s, ld_s, sdi_s, le_s;
  logic sclk_rise, le_rise;

  assign raw_bus = {sclk, ld, sdi, le};

  sig_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
  );

  assign {sclk_s, ld_s, sdi_s, le_s} = sync_bus;

  rise_detect sclk_edge_i (.clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise(sclk_rise));
  rise_detect le_edge_i   (.clk(clk), .rst_n(rst_n), .lvl(le_s),   .rise(le_rise));

  capture_shifter cap_i (
    .clk(clk), .rst_n(rst_n), .step(sclk_rise), .load(ld_s),
    .par(pin_in), .sout(sdo)
  );

  latch_shifter lat_i (
    .clk(clk), .rst_n(rst_n), .step(sclk_rise), .sin(sdi_s),
    .xfer(le_rise), .pout(pout)
  );

  // R1: outputs leave reset at zero
  assert_reset_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (sdo == 1'b0 && pout == '0));
endmodule

// File: tb/spi_io_expander_tb.sv
module spi_io_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int HOLD = 4;

  logic clk = 0, rst_n = 0, sclk = 0, ld = 0, sdi = 0, le = 0;
  logic [W-1:0] pin_in = '0;
  logic sdo;
  logic [W-1:0] pout;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_io_expander dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .ld(ld), .sdi(sdi),
    .le(le), .pin_in(pin_in), .sdo(sdo), .pout(pout));

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edge_sclk(input logic l, input logic d);
    ld = l; sdi = d;
    wait_n(HOLD); sclk = 1;
    wait_n(HOLD); sclk = 0;
    wait_n(HOLD);
  endtask

  task automatic pulse_le();
    le = 1; wait_n(2*HOLD); le = 0; wait_n(HOLD);
  endtask

  task automatic frame(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [W-1:0] prev;
    prev = pout;
    pin_in = p;
    edge_sclk(1'b1, q[W-1]);
    chk(sdo == p[W-1], "R2 load msb", {15'd0, sdo}, {15'd0, p[W-1]});
    for (int k = 1; k < W; k++) begin
      edge_sclk(1'b0, q[W-1-k]);
      chk(sdo == p[W-1-k], "R3 shift bit", {15'd0, sdo}, {15'd0, p[W-1-k]});
    end
    chk(pout == prev, "R6 hold before le", pout, prev);
    le = 1; wait_n(2*HOLD);
    chk(pout == q, "R5/R7 latch word", pout, q);
    edge_sclk(1'b0, ~q[0]);
    chk(sdo == 1'b0, "R3 zero fill", {15'd0, sdo}, 16'd0);
    chk(pout == q, "R7 one transfer per pulse", pout, q);
    le = 0; wait_n(HOLD);
    chk(pout == q, "R7 le fall no change", pout, q);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_fail++; n_chk++;
          $display("FAIL watchdog expired");
          $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
          $finish;
        end
      end
    join_none
  end

  initial begin
    wait_n(3);
    chk(sdo == 0 && pout == 0, "R1 in reset", pout, 16'd0);
    rst_n = 1; wait_n(2);
    chk(sdo == 0 && pout == 0, "R1 after reset", pout, 16'd0);
    pulse_le();
    chk(pout == 0, "R1 input register cleared", pout, 16'd0);

    frame(16'hA5C3, 16'h3C5A);
    frame(16'hFFFF, 16'h0000);
    frame(16'h0000, 16'hFFFF);
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] one;
      one = 16'd1 << i;
      frame(one, ~one);
    end

    pin_in = 16'h8001;
    edge_sclk(1'b1, 1'b0);
    edge_sclk(1'b0, 1'b0);
    edge_sclk(1'b0, 1'b0);
    chk(sdo == 1'b0, "R3 mid word bit", {15'd0, sdo}, 16'd0);
    pin_in = 16'h4000;
    edge_sclk(1'b1, 1'b0);
    chk(sdo == 1'b0, "R4 reload msb", {15'd0, sdo}, 16'd0);
    edge_sclk(1'b0, 1'b0);
    chk(sdo == 1'b1, "R4 reload not shifted", {15'd0, sdo}, 16'd1);

    pin_in = 16'hFFFF;
    for (int k = 0; k < W; k++) edge_sclk(k == 0, 1'b1);
    pulse_le();
    chk(pout == 16'hFFFF, "R5 word of ones", pout, 16'hFFFF);
    pin_in = 16'h8000; edge_sclk(1'b1, 1'b1);
    rst_n = 0; wait_n(2);
    chk(sdo == 0 && pout == 0, "R1 mid frame reset", pout, 16'd0);
    rst_n = 1; wait_n(2);
    pulse_le();
    chk(pout == 0, "R1 input register cleared again", pout, 16'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule